// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block produces the serial-clock timing for an I2C master from the peripheral clock. It divides that clock in three steps. First, a prescaler divides by (A+1), where A is a 2-bit divisor. Next, a second stage divides the prescaler pulses by (B+1), where B is a 6-bit divisor. Last, a fixed half-period counter of 11 base ticks drives a toggle. The serial-clock reference therefore has a period of 22 × (A+1) × (B+1) peripheral clocks and a 50% duty cycle. The block also gives the bit engine a one-cycle strobe four times per serial period.

Control is a small state machine with three states. `SD_IDLE` is the state while enable is low. `SD_HIGH` is the high half of the serial period and `SD_LOW` is the low half. The transitions are:
- start: `SD_IDLE` → `SD_HIGH` when enable is high.
- fall: `SD_HIGH` → `SD_LOW` when the half-period ends.
- rise: `SD_LOW` → `SD_HIGH` when the half-period ends.
- stop: `SD_HIGH` or `SD_LOW` → `SD_IDLE` when enable is low.

The divisor inputs are copied into shadow registers at two times: on every clock while the block is disabled, and at the rise transition. A change made in the middle of a period therefore never shortens or stretches that period. The divisors should be changed only while the bus is idle.

Top module: `scl_tick_gen`

## Requirements
- R1: While reset is asserted, and right after it is released with enable low, `scl_ref` is 1 and `qtr_tick` is 0.
- R2: With enable held high, the `scl_ref` period is exactly 22 × (A+1) × (B+1) clock cycles. A is `div_a` (2 bits) and B is `div_b` (6 bits).
- R3: The shortest period is 22 cycles, with A=0 and B=0. The longest is 5632 cycles, with A=3 and B=63.
- R4: `scl_ref` is high for 11 × (A+1) × (B+1) cycles and low for the same number of cycles. The first fall comes 11 × (A+1) × (B+1) clock edges after the first edge at which enable is sampled high.
- R5: Let N = (A+1) × (B+1) and number the base ticks 1 to 22 within a period, one tick every N clocks. `qtr_tick` is a one-cycle pulse after ticks 6, 11, 17 and 22, which gives four pulses per period. The pulses after ticks 11 and 22 come out in the same cycle as the `scl_ref` transitions.
- R6: On the clock edge at which enable is sampled low, all counters clear, `scl_ref` goes to 1 and `qtr_tick` goes to 0. They stay that way until enable returns. The block then restarts at the beginning of a period.
- R7: A divisor change while enable is high takes effect only at the next rising edge of `scl_ref`. The period in progress keeps its old length.
- R8: While enable is low, the divisors sampled at the last disabled edge set the length of the first period after enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the divider idle |
| div_a | input | 2 | Prescaler divisor A (factor A+1) |
| div_b | input | 6 | Second-stage divisor B (factor B+1) |
| qtr_tick | output | 1 | One-cycle timing strobe, four per serial period |
| scl_ref | output | 1 | Free-running serial-clock reference |

## Verification
The bench uses several divisor pairs:
- A=0, B=0 shows the plain divide-by-22 path.
- A=1, B=2 and A=2, B=4 test the cascade together with the product rule.
- A=3, B=63 confirms that the largest counts wrap correctly.

The bench drops enable in the middle of a period to show the immediate return to idle and the clean restart. It also changes the divisors in the middle of a period to show that the new setting waits for the next rising edge. Every clock is compared against a behavioural tick-count model. This comparison shows an off-by-one in either stage, a lost strobe, or a period boundary in the wrong place.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
    typedef enum logic [1:0] {
        SD_IDLE = 2'd0,
        SD_HIGH = 2'd1,
        SD_LOW  = 2'd2
    } sd_state_e;
endpackage

// File: rtl/scl_div_stage.sv
// Programmable modulo counter: advances on each step, wraps after LIMIT+1 steps.
module scl_div_stage #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    assign wrap = step && (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);
endmodule

// File: rtl/scl_div_ctrl.sv
// Half-period counter and high/low state machine.
module scl_div_ctrl
    import scl_div_pkg::*;
#(
    parameter int HALF_TICKS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic reload,
    output logic scl_ref,
    output logic qtr_tick
);
    localparam int HW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
    localparam logic [HW-1:0] LAST = HW'(HALF_TICKS - 1);
    localparam logic [HW-1:0] MID  = HW'(HALF_TICKS / 2);

    sd_state_e state_q, state_d;
    logic [HW-1:0] half_q;
    logic half_end;
    logic qtr_q;

    assign half_end = tick && (half_q == LAST);
    assign reload   = !en || (half_end && (state_q == SD_LOW));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= '0;
        end else if (!en) begin
            half_q <= '0;
        end else if (tick) begin
            half_q <= half_end ? '0 : half_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SD_IDLE: if (en) state_d = SD_HIGH;
            SD_HIGH: begin
                if (!en)           state_d = SD_IDLE;
                else if (half_end) state_d = SD_LOW;
            end
            SD_LOW: begin
                if (!en)           state_d = SD_IDLE;
                else if (half_end) state_d = SD_HIGH;
            end
            default: state_d = SD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qtr_q <= 1'b0;
        else        qtr_q <= en && tick && ((half_q == LAST) || (half_q == MID));
    end

    always_comb begin
        scl_ref  = (state_q != SD_LOW);
        qtr_tick = qtr_q;
    end

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (scl_ref && !qtr_tick));
    p_edge_has_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(scl_ref) && state_q != SD_IDLE) |-> qtr_tick);
    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        qtr_tick |=> !qtr_tick);
    p_half_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        half_q <= LAST);
endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
    parameter int A_W        = 2,
    parameter int B_W        = 6,
    parameter int HALF_TICKS = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic [A_W-1:0] div_a,
    input  logic [B_W-1:0] div_b,
    output logic           qtr_tick,
    output logic           scl_ref
);
    logic [A_W-1:0] sh_a;
    logic [B_W-1:0] sh_b;
    logic a_wrap, b_wrap, reload;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_a <= '0;
            sh_b <= '0;
        end else if (reload) begin
            sh_a <= div_a;
            sh_b <= div_b;
        end
    end

    scl_div_stage #(.W(A_W)) u_stage_a (
        .clk(clk), .rst_n(rst_n), .clr(!en), .step(en),
        .limit(sh_a), .wrap(a_wrap)
    );

    scl_div_stage #(.W(B_W)) u_stage_b (
        .clk(clk), .rst_n(rst_n), .clr(!en), .step(a_wrap),
        .limit(sh_b), .wrap(b_wrap)
    );

    scl_div_ctrl #(.HALF_TICKS(HALF_TICKS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(b_wrap),
        .reload(reload), .scl_ref(scl_ref), .qtr_tick(qtr_tick)
    );

    p_shadow_at_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && en && !$stable({sh_a, sh_b})) |-> $rose(scl_ref));
endmodule

// File: tb/scl_tick_gen_tb.sv
module scl_tick_gen_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [1:0] div_a = '0;
    logic [5:0] div_b = '0;
    logic qtr_tick, scl_ref;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    scl_tick_gen dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .div_a(div_a), .div_b(div_b),
        .qtr_tick(qtr_tick), .scl_ref(scl_ref)
    );

    // Behavioural reference: tick counting per requirement R2/R5/R6/R7
    int m_phase = 0, m_pos = 0, m_na = 1, m_nb = 1;
    bit m_scl = 1'b1, m_qtr = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_pos = 0; m_scl = 1; m_qtr = 0; m_na = 1; m_nb = 1;
        end else if (!en) begin
            m_phase = 0; m_pos = 0; m_scl = 1; m_qtr = 0;
            m_na = int'(div_a) + 1; m_nb = int'(div_b) + 1;
        end else begin
            m_qtr = 0;
            m_phase++;
            if (m_phase == m_na * m_nb) begin
                m_phase = 0;
                m_pos++;
                m_qtr = (m_pos == 6 || m_pos == 11 || m_pos == 17 || m_pos == 22);
                if (m_pos == 11) m_scl = 0;
                if (m_pos == 22) begin
                    m_scl = 1; m_pos = 0;
                    m_na = int'(div_a) + 1; m_nb = int'(div_b) + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (scl_ref !== m_scl || qtr_tick !== m_qtr) begin
                failures++;
                $display("FAIL R2,R5 cycle model: scl=%0b qtr=%0b expected scl=%0b qtr=%0b",
                         scl_ref, qtr_tick, m_scl, m_qtr);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_rise();
        bit prev;
        prev = scl_ref;
        forever begin
            @(negedge clk);
            if (scl_ref && !prev) break;
            prev = scl_ref;
        end
    endtask

    // Starts on a rise sample; counts one full period.
    task automatic measure(output int per, output int hi, output int q,
                           input int chg_at, input int na, input int nb);
        bit prev;
        per = 0; hi = 0; q = 0; prev = 1'b1;
        forever begin
            @(negedge clk);
            per++;
            if (scl_ref) hi++;
            if (qtr_tick) q++;
            if (per == chg_at) begin div_a = 2'(na); div_b = 6'(nb); end
            if (scl_ref && !prev) break;
            prev = scl_ref;
        end
    endtask

    task automatic start_and_fall(input int a, input int b, input string req);
        int c;
        @(negedge clk);
        en = 0; div_a = 2'(a); div_b = 6'(b);
        @(negedge clk);
        en = 1;
        c = 0;
        do begin @(negedge clk); c++; end while (scl_ref);
        check(req, c, 11 * (a + 1) * (b + 1));
    endtask

    task automatic run_case(input int a, input int b, input string req);
        int per, hi, q;
        start_and_fall(a, b, "R4,R8 first fall");
        wait_rise();
        measure(per, hi, q, -1, 0, 0);
        check(req, per, 22 * (a + 1) * (b + 1));
        check("R4 high time", hi, 11 * (a + 1) * (b + 1));
        check("R5 strobes per period", q, 4);
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int per, hi, q, c;
        repeat (3) @(negedge clk);
        check("R1 scl in reset", int'(scl_ref), 1);
        check("R1 strobe in reset", int'(qtr_tick), 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        check("R1 scl after reset", int'(scl_ref), 1);
        check("R1 strobe after reset", int'(qtr_tick), 0);

        run_case(0, 0, "R3 fastest period");
        run_case(1, 2, "R2 period A=1 B=2");
        run_case(2, 4, "R2 period A=2 B=4");
        run_case(3, 63, "R3 slowest period");

        // R6: disable mid-period
        start_and_fall(1, 1, "R4 first fall A=1 B=1");
        repeat (7) @(negedge clk);
        en = 0;
        @(negedge clk);
        check("R6 scl after disable", int'(scl_ref), 1);
        check("R6 strobe after disable", int'(qtr_tick), 0);
        c = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!scl_ref || qtr_tick) c++;
        end
        check("R6 quiet while disabled", c, 0);
        en = 1;
        c = 0;
        do begin @(negedge clk); c++; end while (scl_ref);
        check("R6 restart fall", c, 44);

        // R7: change mid-period, old period completes, new one next
        wait_rise();
        measure(per, hi, q, 20, 0, 0);
        check("R7 period keeps old length", per, 88);
        measure(per, hi, q, -1, 0, 0);
        check("R7 new length from next rise", per, 22);

        en = 0;
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule